// File: doc/BRIEF.md
# Receive window extension controller

This block decides how long a duty-cycled receiver stays in RX after each wake-up. When the receiver enters RX with the RX timer enabled, the block opens a first listening window (T1). A 4-bit extension mode picks what a detection event inside T1 does. It can do nothing and let T1 run out. It can freeze T1 and hand the receiver to host software. It can keep RX open for as long as the channel-valid flag stays high. It can open a second window (T2) that ends on its own timer. Or it can open T2 and give the receiver to the host as soon as a sync word is found in it.

The detection inputs come from the demodulator and the packet detectors, which are outside this block. They are channel-valid, preamble-detected, sync-detected and node-address-matched. The block reports three things. A one-cycle timeout pulse asks the radio sequencer to leave RX. A hold flag keeps RX under host control. A 2-bit code names the window that is running. Each window lasts `M * 2^(R+1)` time units, where M is an 11-bit mantissa and R a 4-bit exponent. Each unit is `TICK_DIV` clock cycles, which is 20 us at the intended clock.

Top module: `rxwin_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release, `rx_timeout` and `host_hold` are 0 and `win_state` is 0.
- R2: Let N = max(M << (R+1), 1) * TICK_DIV cycles. If RX is entered with the timer enabled and no trigger occurs, `rx_timeout` is high for exactly one cycle, at the (N+1)-th falling-edge sample after `rx_active` is driven high. Entry is the first rising clock edge that sees `rx_active` high after it was low.
- R3: Mode codes 0, 14 and 15 never extend RX. All four detection inputs are ignored and RX times out at the end of T1.
- R4: In modes 1, 2 and 3 the T1 trigger is channel-valid, preamble, and both together. A trigger inside T1 sets `host_hold` from the next clock edge and `win_state` goes to 0. No timeout follows while RX stays active.
- R5: In mode 4, channel-valid inside T1 moves the block to the follow state (`win_state` = 3). RX then persists for as long as channel-valid stays high. The clock edge that first sees it low produces `rx_timeout`.
- R6: Modes 5 to 10 open T2 on these T1 triggers: channel-valid (5), preamble (6), channel-valid and preamble (7), preamble or sync (8), preamble or node match (9), and any of preamble, sync or node match (10). RX then times out when T2 ends, with T2 timed like T1 using its own M and R.
- R7: Modes 11, 12 and 13 open T2 on channel-valid, preamble, and both together. A sync detected in T2 sets `host_hold` and no timeout follows. Without a sync, RX times out when T2 ends.
- R8: Driving `rx_active` low returns the block to idle on the next edge, which clears `host_hold` and `win_state`. Every new entry into RX restarts the windows from zero.
- R9: While `timer_en` is low the block stays idle: no window, no hold and no timeout.
- R10: A trigger seen in the same cycle as the T1 expiry wins over the timeout.
- R11: `win_state` encodes 0 as no window, 1 as T1, 2 as T2 and 3 as follow-channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_active | input | 1 | Receiver is in RX; a rise marks a new entry |
| timer_en | input | 1 | RX timer enable; low keeps the block idle |
| ext_mode | input | 4 | Extension mode code 0..15 |
| t1_mant | input | 11 | T1 mantissa M |
| t1_shift | input | 4 | T1 exponent R |
| t2_mant | input | 11 | T2 mantissa M |
| t2_shift | input | 4 | T2 exponent R |
| chan_valid | input | 1 | Channel-valid detection flag |
| pream_ok | input | 1 | Preamble detected |
| sync_ok | input | 1 | Sync word detected |
| node_ok | input | 1 | Node address matched |
| rx_timeout | output | 1 | One-cycle request to leave RX |
| host_hold | output | 1 | RX held for host control |
| win_state | output | 2 | Current window code |

## Verification
A detection input seen at one rising edge changes `win_state` and `host_hold` at that same edge. A window that expires or a channel-valid that drops raises `rx_timeout` at that edge as well. So every result is due one falling-edge sample after the stimulus that causes it, and a plain timeout comes N+1 samples after `rx_active` is driven. The bench drives inputs and samples outputs only on falling edges. A behavioural model counts elapsed cycles per window and advances on the rising edge, and the bench compares it with the outputs at every falling edge. Directed checks count samples from entry or from the trigger to the pulse, including a trigger placed exactly in the expiry cycle.

// File: rtl/rxwin_pkg.sv
// Shared types for the receive window extension controller.
// Assumes one clock domain; all codes here are internal except win_e,
// whose values appear on the win_state port.
package rxwin_pkg;

    localparam int MODE_W  = 4;
    localparam int NUM_WIN = 2;

    // Sequencer states
    typedef enum logic [2:0] {
        SQ_IDLE   = 3'd0,
        SQ_T1     = 3'd1,
        SQ_T2     = 3'd2,
        SQ_FOLLOW = 3'd3,
        SQ_HOST   = 3'd4,
        SQ_DONE   = 3'd5
    } seq_e;

    // What a T1 trigger leads to
    typedef enum logic [2:0] {
        ACT_NONE     = 3'd0,
        ACT_HOLD     = 3'd1,
        ACT_FOLLOW   = 3'd2,
        ACT_EXTEND   = 3'd3,
        ACT_EXT_SYNC = 3'd4
    } act_e;

    // Window indication seen at the port
    typedef enum logic [1:0] {
        WIN_NONE   = 2'd0,
        WIN_T1     = 2'd1,
        WIN_T2     = 2'd2,
        WIN_FOLLOW = 2'd3
    } win_e;

    // Detection flags from the demodulator and packet detectors
    typedef struct packed {
        logic chan;
        logic pream;
        logic sync;
        logic node;
    } det_t;

endpackage

// File: rtl/rxwin_timer.sv
// Window timer: counts M << (R+1) units of TICK_DIV clocks while run is high.
// Assumes run drops whenever the window is left, which clears both counters,
// so each window starts from zero. expire is high in the last cycle of the
// window; M of zero behaves as a one-unit window.
module rxwin_timer #(
    parameter int TICK_DIV = 5000,
    parameter int M_W      = 11,
    parameter int R_W      = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic [M_W-1:0] mant,
    input  logic [R_W-1:0] shift,
    output logic           expire
);

    localparam int SHIFT_MAX = 1 << R_W;
    localparam int TGT_W     = M_W + SHIFT_MAX;
    localparam int DIV_W     = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic             tick;
    logic [TGT_W-1:0] units;
    logic [TGT_W-1:0] target;
    logic [R_W:0]     sh_amt;
    logic [TGT_W:0]   units_inc;

    generate
        if (TICK_DIV > 1) begin : g_pre
            logic [DIV_W-1:0] pre;

            // Unit prescaler: divides the clock down to one time unit
            always_ff @(posedge clk) begin
                if (!rst_n)
                    pre <= '0;
                else if (!run || tick)
                    pre <= '0;
                else
                    pre <= pre + DIV_W'(1);
            end

            assign tick = run && (pre == DIV_W'(TICK_DIV - 1));
        end else begin : g_nopre
            assign tick = run;
        end
    endgenerate

    // Window length in units and the next unit count
    always_comb begin
        sh_amt    = {1'b0, shift} + (R_W + 1)'(1);
        target    = TGT_W'(mant) << sh_amt;
        units_inc = {1'b0, units} + (TGT_W + 1)'(1);
    end

    // Unit counter: cleared outside the window, advanced on each unit tick
    always_ff @(posedge clk) begin
        if (!rst_n)
            units <= '0;
        else if (!run)
            units <= '0;
        else if (tick)
            units <= units_inc[TGT_W-1:0];
    end

    assign expire = tick && (units_inc >= {1'b0, target});

endmodule

// File: rtl/rxwin_trig.sv
// Trigger decoder: maps the extension mode and the detection flags to a
// T1 trigger and the action it leads to. Purely combinational; unknown
// codes (14, 15) fall back to no extension.
module rxwin_trig
    import rxwin_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  det_t              det,
    output logic              fire,
    output act_e              act
);

    // Condition that counts as a trigger inside T1
    always_comb begin
        unique case (mode)
            4'd1, 4'd5, 4'd11: fire = det.chan;
            4'd2, 4'd6, 4'd12: fire = det.pream;
            4'd3, 4'd7, 4'd13: fire = det.chan && det.pream;
            4'd4:              fire = det.chan;
            4'd8:              fire = det.pream || det.sync;
            4'd9:              fire = det.pream || det.node;
            4'd10:             fire = det.pream || det.sync || det.node;
            default:           fire = 1'b0;
        endcase
    end

    // Action group of the mode
    always_comb begin
        unique case (mode)
            4'd1, 4'd2, 4'd3:                       act = ACT_HOLD;
            4'd4:                                   act = ACT_FOLLOW;
            4'd5, 4'd6, 4'd7, 4'd8, 4'd9, 4'd10:    act = ACT_EXTEND;
            4'd11, 4'd12, 4'd13:                    act = ACT_EXT_SYNC;
            default:                                act = ACT_NONE;
        endcase
    end

endmodule

// File: rtl/rxwin_seq.sv
// Window sequencer: tracks entry into RX and walks T1, T2, follow, host and
// done states. Assumes the timer expiries come from timers that run only in
// their own state. A trigger is checked before the expiry of the same cycle.
module rxwin_seq
    import rxwin_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_active,
    input  logic       timer_en,
    input  logic       fire,
    input  act_e       act,
    input  logic       sync_seen,
    input  logic       chan_seen,
    input  logic       t1_done,
    input  logic       t2_done,
    output logic       run_t1,
    output logic       run_t2,
    output logic       rx_timeout,
    output logic       host_hold,
    output logic [1:0] win_state
);

    seq_e state, state_nx;
    logic rx_prev;
    logic entry;
    logic to_nx;

    assign entry = rx_active && !rx_prev;

    // Remember rx_active to find its rising edge
    always_ff @(posedge clk) begin
        if (!rst_n)
            rx_prev <= 1'b0;
        else
            rx_prev <= rx_active;
    end

    // Next-state and timeout decision
    always_comb begin
        state_nx = state;
        to_nx    = 1'b0;
        if (!timer_en || !rx_active) begin
            state_nx = SQ_IDLE;
        end else begin
            unique case (state)
                SQ_IDLE: begin
                    if (entry)
                        state_nx = SQ_T1;
                end
                SQ_T1: begin
                    if (fire) begin
                        unique case (act)
                            ACT_HOLD:     state_nx = SQ_HOST;
                            ACT_FOLLOW:   state_nx = SQ_FOLLOW;
                            ACT_EXTEND:   state_nx = SQ_T2;
                            ACT_EXT_SYNC: state_nx = SQ_T2;
                            default:      state_nx = SQ_T1;
                        endcase
                    end else if (t1_done) begin
                        state_nx = SQ_DONE;
                        to_nx    = 1'b1;
                    end
                end
                SQ_T2: begin
                    if ((act == ACT_EXT_SYNC) && sync_seen) begin
                        state_nx = SQ_HOST;
                    end else if (t2_done) begin
                        state_nx = SQ_DONE;
                        to_nx    = 1'b1;
                    end
                end
                SQ_FOLLOW: begin
                    if (!chan_seen) begin
                        state_nx = SQ_DONE;
                        to_nx    = 1'b1;
                    end
                end
                default: state_nx = state;
            endcase
        end
    end

    // State and timeout pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= SQ_IDLE;
            rx_timeout <= 1'b0;
        end else begin
            state      <= state_nx;
            rx_timeout <= to_nx;
        end
    end

    // Output decode from the registered state
    always_comb begin
        run_t1    = (state == SQ_T1);
        run_t2    = (state == SQ_T2);
        host_hold = (state == SQ_HOST);
        unique case (state)
            SQ_T1:     win_state = WIN_T1;
            SQ_T2:     win_state = WIN_T2;
            SQ_FOLLOW: win_state = WIN_FOLLOW;
            default:   win_state = WIN_NONE;
        endcase
    end

endmodule

// File: rtl/rxwin_ctrl.sv
// Receive window extension controller, top level.
// Builds one timer per window with a generate loop, decodes the extension
// mode into a trigger and action, and sequences the windows. Assumes the
// detection flags are synchronous to clk and the window settings only change
// while rx_active is low.
module rxwin_ctrl
    import rxwin_pkg::*;
#(
    parameter int TICK_DIV = 5000,
    parameter int M_W      = 11,
    parameter int R_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_active,
    input  logic              timer_en,
    input  logic [MODE_W-1:0] ext_mode,
    input  logic [M_W-1:0]    t1_mant,
    input  logic [R_W-1:0]    t1_shift,
    input  logic [M_W-1:0]    t2_mant,
    input  logic [R_W-1:0]    t2_shift,
    input  logic              chan_valid,
    input  logic              pream_ok,
    input  logic              sync_ok,
    input  logic              node_ok,
    output logic              rx_timeout,
    output logic              host_hold,
    output logic [1:0]        win_state
);

    det_t               det;
    logic               fire;
    act_e               act;
    logic [NUM_WIN-1:0] run_v;
    logic [NUM_WIN-1:0] exp_v;
    logic [M_W-1:0]     mant_a [NUM_WIN];
    logic [R_W-1:0]     sh_a   [NUM_WIN];

    // Bundle the detection flags and the window settings
    always_comb begin
        det.chan  = chan_valid;
        det.pream = pream_ok;
        det.sync  = sync_ok;
        det.node  = node_ok;
        mant_a[0] = t1_mant;
        sh_a[0]   = t1_shift;
        mant_a[1] = t2_mant;
        sh_a[1]   = t2_shift;
    end

    rxwin_trig u_trig (
        .mode (ext_mode),
        .det  (det),
        .fire (fire),
        .act  (act)
    );

    genvar g;
    generate
        for (g = 0; g < NUM_WIN; g++) begin : g_win
            rxwin_timer #(
                .TICK_DIV (TICK_DIV),
                .M_W      (M_W),
                .R_W      (R_W)
            ) u_tmr (
                .clk    (clk),
                .rst_n  (rst_n),
                .run    (run_v[g]),
                .mant   (mant_a[g]),
                .shift  (sh_a[g]),
                .expire (exp_v[g])
            );
        end
    endgenerate

    rxwin_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_active  (rx_active),
        .timer_en   (timer_en),
        .fire       (fire),
        .act        (act),
        .sync_seen  (sync_ok),
        .chan_seen  (chan_valid),
        .t1_done    (exp_v[0]),
        .t2_done    (exp_v[1]),
        .run_t1     (run_v[0]),
        .run_t2     (run_v[1]),
        .rx_timeout (rx_timeout),
        .host_hold  (host_hold),
        .win_state  (win_state)
    );

endmodule

// File: rtl/rxwin_chk.sv
// Checker for rxwin_ctrl: port-level properties over time. Bound to every
// instance of the top module.
module rxwin_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_active,
    input logic       timer_en,
    input logic       chan_valid,
    input logic       rx_timeout,
    input logic       host_hold,
    input logic [1:0] win_state
);

    AST_TIMEOUT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_timeout |=> !rx_timeout);                                              // R2

    AST_TIMEOUT_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        rx_timeout |-> $past(win_state) != 2'd0);                                 // R2

    AST_HOLD_NO_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        host_hold |-> (win_state == 2'd0) && !rx_timeout);                        // R4

    AST_FOLLOW_DROP_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
        (win_state == 2'd3 && !chan_valid && rx_active && timer_en) |=> rx_timeout); // R5

    AST_RX_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_active |=> (win_state == 2'd0) && !host_hold && !rx_timeout);         // R8

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !timer_en |=> (win_state == 2'd0) && !host_hold && !rx_timeout);          // R9

endmodule

bind rxwin_ctrl rxwin_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_active  (rx_active),
    .timer_en   (timer_en),
    .chan_valid (chan_valid),
    .rx_timeout (rx_timeout),
    .host_hold  (host_hold),
    .win_state  (win_state)
);

// File: tb/rxwin_ctrl_test.sv
`timescale 1ns/1ps
module rxwin_ctrl_test;

    localparam int DIV = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_active = 1'b0;
    logic        timer_en = 1'b1;
    logic [3:0]  ext_mode = 4'd0;
    logic [10:0] t1_mant = 11'd3;
    logic [3:0]  t1_shift = 4'd0;
    logic [10:0] t2_mant = 11'd2;
    logic [3:0]  t2_shift = 4'd1;
    logic        chan_valid = 1'b0;
    logic        pream_ok = 1'b0;
    logic        sync_ok = 1'b0;
    logic        node_ok = 1'b0;
    logic        rx_timeout;
    logic        host_hold;
    logic [1:0]  win_state;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    cmp_on = 0;
    bit    done = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;   // 250 MHz

    rxwin_ctrl #(.TICK_DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .rx_active(rx_active), .timer_en(timer_en),
        .ext_mode(ext_mode), .t1_mant(t1_mant), .t1_shift(t1_shift),
        .t2_mant(t2_mant), .t2_shift(t2_shift), .chan_valid(chan_valid),
        .pream_ok(pream_ok), .sync_ok(sync_ok), .node_ok(node_ok),
        .rx_timeout(rx_timeout), .host_hold(host_hold), .win_state(win_state)
    );

    // ---------------- behavioural reference ----------------
    function automatic int wlen(int m, int r);
        int t = m << (r + 1);
        if (t < 1) t = 1;
        return t * DIV;
    endfunction

    // 0 none, 1 host, 2 follow, 3 second window, 4 second window with sync hand-off
    function automatic int kind(int md);
        if (md >= 1 && md <= 3)   return 1;
        if (md == 4)              return 2;
        if (md >= 5 && md <= 10)  return 3;
        if (md >= 11 && md <= 13) return 4;
        return 0;
    endfunction

    function automatic bit cond(int md, bit c, bit p, bit s, bit n);
        case (md)
            1, 5, 11: return c;
            2, 6, 12: return p;
            3, 7, 13: return c && p;
            4:        return c;
            8:        return p || s;
            9:        return p || n;
            10:       return p || s || n;
            default:  return 0;
        endcase
    endfunction

    int m_st = 0;   // 0 idle, 1 first, 2 second, 3 follow, 4 host, 5 done
    int m_cyc = 0;
    bit m_prev = 0;
    bit m_to = 0;
    bit m_edge;
    int m_k;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cyc = 0; m_prev = 0; m_to = 0;
        end else begin
            m_edge = rx_active && !m_prev;
            m_prev = rx_active;
            m_to = 0;
            if (!timer_en || !rx_active) begin
                m_st = 0;
            end else begin
                case (m_st)
                    0: if (m_edge) begin m_st = 1; m_cyc = 0; end
                    1: begin
                        m_cyc++;
                        if (cond(ext_mode, chan_valid, pream_ok, sync_ok, node_ok)) begin
                            m_k = kind(ext_mode);
                            m_st = (m_k == 1) ? 4 : (m_k == 2) ? 3 : 2;
                            m_cyc = 0;
                        end else if (m_cyc >= wlen(t1_mant, t1_shift)) begin
                            m_st = 5; m_to = 1;
                        end
                    end
                    2: begin
                        m_cyc++;
                        if (kind(ext_mode) == 4 && sync_ok) m_st = 4;
                        else if (m_cyc >= wlen(t2_mant, t2_shift)) begin
                            m_st = 5; m_to = 1;
                        end
                    end
                    3: if (!chan_valid) begin m_st = 5; m_to = 1; end
                    default: ;
                endcase
            end
        end
    end

    // Compare the outputs with the reference at every falling edge
    always @(negedge clk) begin
        if (cmp_on) begin
            int ew;
            ew = (m_st >= 1 && m_st <= 3) ? m_st : 0;
            n_cmp++;
            if (rx_timeout !== m_to || host_hold !== (m_st == 4) || win_state !== 2'(ew)) begin
                n_bad++;
                $display("FAIL %s model t=%0t: to/hold/win act %0b/%0b/%0d exp %0b/%0b/%0d",
                         cur_req, $time, rx_timeout, host_hold, win_state, m_to, (m_st == 4), ew);
            end
        end
    end

    // ---------------- directed helpers ----------------
    task automatic chk(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: act %0d exp %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_flags();
        chan_valid = 0; pream_ok = 0; sync_ok = 0; node_ok = 0;
    endtask

    task automatic leave_rx();
        @(negedge clk);
        rx_active = 0;
        clear_flags();
        repeat (2) @(negedge clk);
    endtask

    // Drive rx_active high at a falling edge (sample 0)
    task automatic enter_rx(int md);
        @(negedge clk);
        ext_mode = 4'(md);
        rx_active = 1;
    endtask

    // Count falling-edge samples until rx_timeout is seen
    task automatic wait_to(output int k, input int lim);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!rx_timeout && k < lim);
    endtask

    task automatic watch_no_to(input int n, output int seen);
        seen = 0;
        repeat (n) begin
            @(negedge clk);
            if (rx_timeout) seen++;
        end
    endtask

    localparam int LEN1 = 12;   // 3 << 1 units of 2 cycles
    localparam int LEN2 = 16;   // 2 << 2 units of 2 cycles

    initial begin
        int k;
        int seen;

        // Reset state (R1)
        repeat (3) @(negedge clk);
        chk("R1", "timeout in reset", rx_timeout, 0);
        chk("R1", "window in reset", win_state, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1", "hold after reset", host_hold, 0);
        cmp_on = 1;

        // Plain T1 timeout and window code (R2, R11)
        cur_req = "R2";
        enter_rx(0);
        @(negedge clk);
        chk("R11", "T1 code", win_state, 1);
        wait_to(k, 100);
        chk("R2", "T1 samples to timeout", k + 1, LEN1 + 1);
        @(negedge clk);
        chk("R2", "pulse width", rx_timeout, 0);
        leave_rx();

        // M of zero is a one-unit window (R2)
        t1_mant = 0;
        enter_rx(0);
        wait_to(k, 100);
        chk("R2", "zero mantissa window", k, DIV + 1);
        leave_rx();
        t1_mant = 3;

        // Mode 0 and 15 ignore detections (R3)
        cur_req = "R3";
        enter_rx(0);
        chan_valid = 1; pream_ok = 1; sync_ok = 1; node_ok = 1;
        wait_to(k, 100);
        chk("R3", "mode 0 with all flags", k, LEN1 + 1);
        leave_rx();
        enter_rx(15);
        chan_valid = 1; pream_ok = 1; sync_ok = 1; node_ok = 1;
        wait_to(k, 100);
        chk("R3", "mode 15 with all flags", k, LEN1 + 1);
        leave_rx();

        // Mode 2 hands to host on preamble (R4), rx low clears it (R8)
        cur_req = "R4";
        enter_rx(2);
        repeat (4) @(negedge clk);
        pream_ok = 1;
        @(negedge clk);
        pream_ok = 0;
        chk("R4", "hold after preamble", host_hold, 1);
        chk("R4", "window code under hold", win_state, 0);
        watch_no_to(40, seen);
        chk("R4", "timeouts while held", seen, 0);
        @(negedge clk);
        rx_active = 0;
        @(negedge clk);
        chk("R8", "hold cleared by rx low", host_hold, 0);
        leave_rx();

        // Mode 3 needs both flags: channel alone does not trigger (R4)
        enter_rx(3);
        chan_valid = 1;
        wait_to(k, 100);
        chk("R4", "mode 3 partial trigger", k, LEN1 + 1);
        leave_rx();

        // Mode 4 follows channel-valid (R5)
        cur_req = "R5";
        enter_rx(4);
        repeat (2) @(negedge clk);
        chan_valid = 1;
        watch_no_to(30, seen);
        chk("R5", "timeouts while channel valid", seen, 0);
        chk("R11", "follow code", win_state, 3);
        chan_valid = 0;
        wait_to(k, 10);
        chk("R5", "samples from drop to timeout", k, 1);
        leave_rx();

        // Mode 9 opens T2 on node match (R6)
        cur_req = "R6";
        enter_rx(9);
        repeat (3) @(negedge clk);
        node_ok = 1;
        @(negedge clk);
        node_ok = 0;
        chk("R11", "T2 code", win_state, 2);
        wait_to(k, 100);
        chk("R6", "T2 length after node match", k, LEN2);
        leave_rx();

        // Mode 8 opens T2 on sync alone (R6)
        enter_rx(8);
        repeat (5) @(negedge clk);
        sync_ok = 1;
        @(negedge clk);
        sync_ok = 0;
        wait_to(k, 100);
        chk("R6", "T2 length after sync", k, LEN2);
        leave_rx();

        // Mode 12: sync in T2 hands to host (R7)
        cur_req = "R7";
        enter_rx(12);
        repeat (2) @(negedge clk);
        pream_ok = 1;
        @(negedge clk);
        pream_ok = 0;
        repeat (4) @(negedge clk);
        sync_ok = 1;
        @(negedge clk);
        sync_ok = 0;
        chk("R7", "hold after sync in T2", host_hold, 1);
        watch_no_to(30, seen);
        chk("R7", "timeouts after sync hand-off", seen, 0);
        leave_rx();

        // Mode 13 without sync ends at T2 expiry (R7)
        enter_rx(13);
        repeat (2) @(negedge clk);
        chan_valid = 1; pream_ok = 1;
        @(negedge clk);
        chan_valid = 0; pream_ok = 0;
        wait_to(k, 100);
        chk("R7", "T2 length without sync", k, LEN2);
        leave_rx();

        // Trigger in the expiry cycle wins (R10)
        cur_req = "R10";
        enter_rx(1);
        repeat (LEN1) @(negedge clk);
        chan_valid = 1;
        @(negedge clk);
        chan_valid = 0;
        chk("R10", "hold on expiry-cycle trigger", host_hold, 1);
        chk("R10", "no timeout on expiry-cycle trigger", rx_timeout, 0);
        leave_rx();

        // Timer disabled keeps the block idle (R9)
        cur_req = "R9";
        timer_en = 0;
        enter_rx(5);
        chan_valid = 1;
        watch_no_to(40, seen);
        chk("R9", "timeouts while disabled", seen, 0);
        chk("R9", "window while disabled", win_state, 0);
        leave_rx();
        timer_en = 1;

        // Leaving and re-entering restarts T1 from zero (R8)
        cur_req = "R8";
        enter_rx(0);
        repeat (6) @(negedge clk);
        rx_active = 0;
        @(negedge clk);
        chk("R8", "idle after rx low", win_state, 0);
        rx_active = 1;
        wait_to(k, 100);
        chk("R8", "full T1 after re-entry", k, LEN1 + 1);
        leave_rx();

        // Pseudo-random traffic against the reference (R2..R11)
        cur_req = "R6";
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            if (!rx_active) begin
                ext_mode = 4'($urandom_range(0, 15));
                t1_mant  = 11'($urandom_range(0, 3));
                t1_shift = 4'($urandom_range(0, 1));
                t2_mant  = 11'($urandom_range(0, 3));
                t2_shift = 4'($urandom_range(0, 1));
                if ($urandom_range(0, 9) == 0) rx_active = 1;
            end else if ($urandom_range(0, 39) == 0) begin
                rx_active = 0;
            end
            timer_en   = ($urandom_range(0, 199) != 0);
            chan_valid = ($urandom_range(0, 9) == 0) ? ~chan_valid : chan_valid;
            pream_ok   = ($urandom_range(0, 11) == 0);
            sync_ok    = ($urandom_range(0, 13) == 0);
            node_ok    = ($urandom_range(0, 13) == 0);
        end
        leave_rx();

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: act running exp finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule